// File: doc/BRIEF.md
# 10BASE-T Transmit Heartbeat and Jabber Supervisor

This block sits on the transmit side of a 10BASE-T port. It does two jobs, and each has its own enable.

The first job is the heartbeat. When the heartbeat enable is set, the block marks the end of every normally completed packet with a short pulse on the collision output. The pulse starts a fixed number of bit times after transmit-enable falls.

The second job is the jabber guard. It measures how long each single transmission lasts. When a transmission runs past the jabber limit, the block blocks both the transmit path and the loopback path and raises a status flag. Once transmit-enable has been released, it lifts the block again after a recovery interval.

Time is measured in bit-time ticks taken from `bit_tick_i`. All timers move only on clock edges where the tick is high. Every output is plain control or status, so there is no data stream and no handshake at the boundary.

The parameters are:
- `JAB_LIMIT`: the jabber limit, in ticks. The default is 200000, which is 20 ms at 10 Mb/s.
- `UNJAB_TIME`: the recovery interval, in ticks. The default is 5000000, which is 500 ms.
- `HB_DELAY`: the heartbeat start delay, in ticks. It must be at least 1.
- `HB_LEN`: the heartbeat length, in ticks. It must be between 5 and 15.

Top module: `tp10_tx_guard`

## Requirements
- R1: After reset, `jab_o` and `col_o` are 0, `lpbk_ok_o` is 1, and `tx_en_o` follows `tx_en_i`.
- R2: While `jab_o` is 0, `tx_en_o` equals `tx_en_i` and `lpbk_ok_o` is 1.
- R3: With `hb_on_i`=1, suppose a packet ends normally, seen at the clock edge where `tx_en_i` is sampled 0 after being 1. Then `col_o` rises at the edge that completes `HB_DELAY` ticks after that edge. It stays high for exactly `HB_LEN` ticks and then falls.
- R4: With `hb_on_i`=0, `col_o` stays 0. Clearing `hb_on_i` also ends a heartbeat that is pending or running.
- R5: With `jab_off_i`=0, `jab_o` rises at the edge where the `JAB_LIMIT`-th tick is counted while `tx_en_i` is continuously 1. The count restarts whenever `tx_en_i` is 0.
- R6: While `jab_o` is 1, `tx_en_o` is 0 and `lpbk_ok_o` is 0, whatever the value of `tx_en_i`.
- R7: `jab_o` falls at the edge where the `UNJAB_TIME`-th tick is counted with `tx_en_i` continuously 0. Any tick-time with `tx_en_i`=1 restarts that interval from zero.
- R8: With `jab_off_i`=1, jabber never occurs. Setting `jab_off_i` while in jabber clears `jab_o` at the next edge.
- R9: A packet that ends while `jab_o` is 1 produces no heartbeat.
- R10: If `tx_en_i` rises while a heartbeat is pending or running, that heartbeat is abandoned and `col_o` is 0 from the next edge on.
- R11: On edges where `bit_tick_i` is 0, the jabber and heartbeat timers hold their counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en_i | input | 1 | Transmit enable from the MAC side |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| jab_off_i | input | 1 | 1 disables the jabber guard |
| hb_on_i | input | 1 | 1 enables the post-packet heartbeat |
| tx_en_o | output | 1 | Gated transmit enable toward the line driver |
| lpbk_ok_o | output | 1 | 1 while loopback is allowed |
| col_o | output | 1 | Collision output carrying the heartbeat pulse |
| jab_o | output | 1 | 1 while in jabber mode |

## Verification
The bench builds the block with `JAB_LIMIT`=20, `UNJAB_TIME`=30, `HB_DELAY`=3 and `HB_LEN`=6. With these values, the exact cycle of jabber entry, the release after the recovery interval, and a restarted recovery can all be reached in a few hundred cycles. The same holds for both edges of the heartbeat pulse. Holding the tick low for longer than the jabber limit shows that the timers count bit times rather than clock cycles.

// File: rtl/tp10_guard_pkg.sv
package tp10_guard_pkg;

  typedef enum logic {
    JG_TRACK = 1'b0,
    JG_CUT   = 1'b1
  } jg_state_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_WAIT  = 2'd1,
    SQ_PULSE = 2'd2
  } sq_state_t;

endpackage

// File: rtl/tp10_jab_guard.sv
module tp10_jab_guard
  import tp10_guard_pkg::*;
#(
  parameter int JAB_LIMIT  = 200000,
  parameter int UNJAB_TIME = 5000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en_i,
  input  logic tick_i,
  input  logic jab_off_i,
  output logic jab_o
);

  localparam int MAXV = (JAB_LIMIT > UNJAB_TIME) ? JAB_LIMIT : UNJAB_TIME;
  localparam int CW   = $clog2(MAXV + 1);
  localparam logic [CW-1:0] JAB_LAST   = CW'(JAB_LIMIT - 1);
  localparam logic [CW-1:0] UNJAB_LAST = CW'(UNJAB_TIME - 1);

  jg_state_t     state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || jab_off_i) begin
      state <= JG_TRACK;
      cnt   <= '0;
    end else begin
      case (state)
        JG_TRACK: begin
          // measure the length of the current transmission
          if (!tx_en_i) begin
            cnt <= '0;
          end else if (tick_i) begin
            if (cnt == JAB_LAST) begin
              state <= JG_CUT;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          // recovery runs only while transmit is released
          if (tx_en_i) begin
            cnt <= '0;
          end else if (tick_i) begin
            if (cnt == UNJAB_LAST) begin
              state <= JG_TRACK;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign jab_o = (state == JG_CUT);

endmodule

// File: rtl/tp10_sqe_pulser.sv
module tp10_sqe_pulser
  import tp10_guard_pkg::*;
#(
  parameter int HB_DELAY = 4,
  parameter int HB_LEN   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en_i,
  input  logic tick_i,
  input  logic hb_on_i,
  input  logic jab_i,
  output logic col_o
);

  localparam int MAXV = (HB_DELAY > HB_LEN) ? HB_DELAY : HB_LEN;
  localparam int CW   = $clog2(MAXV + 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(HB_DELAY - 1);
  localparam logic [CW-1:0] LEN_LAST = CW'(HB_LEN - 1);

  sq_state_t     state;
  logic [CW-1:0] cnt;
  logic          tx_prev;
  logic          end_seen;

  // a packet ends normally: transmit falls while no jabber cut is active
  assign end_seen = tx_prev && !tx_en_i && !jab_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_prev <= 1'b0;
    end else begin
      tx_prev <= tx_en_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !hb_on_i || tx_en_i) begin
      state <= SQ_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (end_seen) begin
            state <= SQ_WAIT;
            cnt   <= '0;
          end
        end
        SQ_WAIT: begin
          if (tick_i) begin
            if (cnt == DLY_LAST) begin
              state <= SQ_PULSE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        SQ_PULSE: begin
          if (tick_i) begin
            if (cnt == LEN_LAST) begin
              state <= SQ_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          state <= SQ_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign col_o = (state == SQ_PULSE);

endmodule

// File: rtl/tp10_tx_guard.sv
module tp10_tx_guard #(
  parameter int JAB_LIMIT  = 200000,
  parameter int UNJAB_TIME = 5000000,
  parameter int HB_DELAY   = 4,
  parameter int HB_LEN     = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en_i,
  input  logic bit_tick_i,
  input  logic jab_off_i,
  input  logic hb_on_i,
  output logic tx_en_o,
  output logic lpbk_ok_o,
  output logic col_o,
  output logic jab_o
);

  logic cut;

  tp10_jab_guard #(
    .JAB_LIMIT (JAB_LIMIT),
    .UNJAB_TIME(UNJAB_TIME)
  ) u_jab (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en_i  (tx_en_i),
    .tick_i   (bit_tick_i),
    .jab_off_i(jab_off_i),
    .jab_o    (cut)
  );

  tp10_sqe_pulser #(
    .HB_DELAY(HB_DELAY),
    .HB_LEN  (HB_LEN)
  ) u_sqe (
    .clk    (clk),
    .rst_n  (rst_n),
    .tx_en_i(tx_en_i),
    .tick_i (bit_tick_i),
    .hb_on_i(hb_on_i),
    .jab_i  (cut),
    .col_o  (col_o)
  );

  assign tx_en_o   = tx_en_i && !cut;
  assign lpbk_ok_o = !cut;
  assign jab_o     = cut;

endmodule

// File: rtl/tp10_guard_chk.sv
module tp10_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en_i,
  input logic jab_off_i,
  input logic hb_on_i,
  input logic tx_en_o,
  input logic lpbk_ok_o,
  input logic col_o,
  input logic jab_o
);

  a_r6_cut_blocks_paths: assert property (@(posedge clk) disable iff (!rst_n)
    jab_o |-> (!tx_en_o && !lpbk_ok_o));

  a_r2_pass_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !jab_o |-> (tx_en_o == tx_en_i && lpbk_ok_o));

  a_r8_off_clears_jab: assert property (@(posedge clk) disable iff (!rst_n)
    jab_off_i |=> !jab_o);

  a_r4_no_pulse_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !hb_on_i |=> !col_o);

  a_r3_pulse_starts_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_o) |-> !tx_en_i);

  a_r10_new_tx_ends_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_i |=> !col_o);

  a_r7_release_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(jab_o) && !$past(jab_off_i)) |-> !$past(tx_en_i));

endmodule

bind tp10_tx_guard tp10_guard_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_en_i  (tx_en_i),
  .jab_off_i(jab_off_i),
  .hb_on_i  (hb_on_i),
  .tx_en_o  (tx_en_o),
  .lpbk_ok_o(lpbk_ok_o),
  .col_o    (col_o),
  .jab_o    (jab_o)
);

// File: tb/tp10_tx_guard_test.sv
module tp10_tx_guard_test;

  localparam int PERIOD = 10;
  localparam int JL = 20;
  localparam int UT = 30;
  localparam int HD = 3;
  localparam int HL = 6;

  logic clk = 1'b0;
  logic rst_n, tx_en_i, bit_tick_i, jab_off_i, hb_on_i;
  logic tx_en_o, lpbk_ok_o, col_o, jab_o;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  tp10_tx_guard #(
    .JAB_LIMIT(JL), .UNJAB_TIME(UT), .HB_DELAY(HD), .HB_LEN(HL)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en_i), .bit_tick_i(bit_tick_i),
    .jab_off_i(jab_off_i), .hb_on_i(hb_on_i), .tx_en_o(tx_en_o),
    .lpbk_ok_o(lpbk_ok_o), .col_o(col_o), .jab_o(jab_o)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    tx_en_i = 1'b0;
    step(HD + HL + 4);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tx_en_i = 1'b0; bit_tick_i = 1'b1; jab_off_i = 1'b0; hb_on_i = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    check("R1 jab", jab_o, 1'b0);
    check("R1 col", col_o, 1'b0);
    check("R1 lpbk", lpbk_ok_o, 1'b1);
    tx_en_i = 1'b1;
    #1;
    check("R1 tx follows", tx_en_o, 1'b1);
    tx_en_i = 1'b0;
    step(1);
  endtask

  task automatic t_heartbeat();
    hb_on_i = 1'b1;
    tx_en_i = 1'b1;
    step(5);
    check("R2 tx pass", tx_en_o, 1'b1);
    check("R2 lpbk", lpbk_ok_o, 1'b1);
    tx_en_i = 1'b0;
    step(HD);
    check("R3 before start", col_o, 1'b0);
    step(1);
    check("R3 start", col_o, 1'b1);
    step(HL - 1);
    check("R3 last tick", col_o, 1'b1);
    step(1);
    check("R3 end", col_o, 1'b0);
    settle();
  endtask

  task automatic t_hb_off();
    hb_on_i = 1'b0;
    tx_en_i = 1'b1;
    step(4);
    tx_en_i = 1'b0;
    for (int i = 0; i < HD + HL + 2; i++) begin
      step(1);
      check("R4 no heartbeat", col_o, 1'b0);
    end
    hb_on_i = 1'b1;
    tx_en_i = 1'b1;
    step(4);
    tx_en_i = 1'b0;
    step(HD + 2);
    hb_on_i = 1'b0;
    step(1);
    check("R4 clear ends pulse", col_o, 1'b0);
    settle();
    hb_on_i = 1'b1;
  endtask

  task automatic t_jabber();
    hb_on_i = 1'b1;
    tx_en_i = 1'b1;
    step(JL - 1);
    check("R5 before limit", jab_o, 1'b0);
    step(1);
    check("R5 at limit", jab_o, 1'b1);
    check("R6 tx cut", tx_en_o, 1'b0);
    check("R6 lpbk cut", lpbk_ok_o, 1'b0);
    step(10);
    check("R6 held", jab_o, 1'b1);
    tx_en_i = 1'b0;
    for (int i = 0; i < HD + HL + 2; i++) begin
      step(1);
      check("R9 no heartbeat after cut", col_o, 1'b0);
    end
    step(UT - 1 - (HD + HL + 2));
    check("R7 before release", jab_o, 1'b1);
    step(1);
    check("R7 release", jab_o, 1'b0);
    check("R7 lpbk back", lpbk_ok_o, 1'b1);
    settle();
  endtask

  task automatic t_restart();
    tx_en_i = 1'b1;
    step(JL);
    check("R5 cut again", jab_o, 1'b1);
    tx_en_i = 1'b0;
    step(10);
    tx_en_i = 1'b1;
    step(3);
    check("R6 tx blocked while cut", tx_en_o, 1'b0);
    tx_en_i = 1'b0;
    step(UT - 1);
    check("R7 restarted interval", jab_o, 1'b1);
    step(1);
    check("R7 restarted release", jab_o, 1'b0);
    settle();
  endtask

  task automatic t_jab_off();
    hb_on_i = 1'b0;
    tx_en_i = 1'b1;
    step(JL);
    check("R5 cut", jab_o, 1'b1);
    jab_off_i = 1'b1;
    step(1);
    check("R8 clears cut", jab_o, 1'b0);
    check("R8 tx restored", tx_en_o, 1'b1);
    step(JL + 10);
    check("R8 no jabber", jab_o, 1'b0);
    tx_en_i = 1'b0;
    step(2);
    jab_off_i = 1'b0;
    settle();
    hb_on_i = 1'b1;
  endtask

  task automatic t_ticks();
    bit_tick_i = 1'b0;
    tx_en_i = 1'b1;
    step(JL + 10);
    check("R11 no count without tick", jab_o, 1'b0);
    bit_tick_i = 1'b1;
    step(JL - 1);
    check("R11 count from zero", jab_o, 1'b0);
    step(1);
    check("R11 limit in ticks", jab_o, 1'b1);
    tx_en_i = 1'b0;
    step(UT);
    check("R7 release", jab_o, 1'b0);
    settle();
  endtask

  task automatic t_abort();
    hb_on_i = 1'b1;
    tx_en_i = 1'b1;
    step(4);
    tx_en_i = 1'b0;
    step(2);
    tx_en_i = 1'b1;
    for (int i = 0; i < HD + HL + 2; i++) begin
      step(1);
      check("R10 pending dropped", col_o, 1'b0);
    end
    tx_en_i = 1'b0;
    step(HD + 2);
    check("R3 pulse on", col_o, 1'b1);
    tx_en_i = 1'b1;
    step(1);
    check("R10 pulse dropped", col_o, 1'b0);
    settle();
  endtask

  initial begin
    t_reset();
    t_heartbeat();
    t_hb_off();
    t_jabber();
    t_restart();
    t_jab_off();
    t_ticks();
    t_abort();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule